// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block monitors forty general-purpose input pins, grouped as five ports of eight, and turns chosen transitions on them into interrupt requests. Each input is synchronized into the clock domain before its edges are detected. Each enabled pin has a sticky pending flag. A port's request line is high whenever any pending flag of that port is set. Pins 2, 3 and 4 of port 0 also drive three dedicated request lines. Each dedicated line has its own pending flag, which software clears separately from the shared port-0 flags.

The two lower ports are configured pin by pin: an enable bit and an edge-select bit per pin. Ports 2, 3 and 4 each take one enable bit and one edge-select bit that apply to all eight of their pins. Software reaches the block through one address bus. In a cycle where `wr_en_i` is high, the address selects a register to write. In every cycle, the same address selects the register returned on `rd_data_o` one clock later. Pending registers are write-one-to-clear.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every register reads 0, and `port_irq_o` and `ded_irq_o` are 0.
- R2: Ports 0 and 1 have a per-pin enable register at addresses 0 and 1 and a per-pin edge register at addresses 2 and 3. Register bit b controls pin b. An edge bit of 1 selects the rising edge and 0 selects the falling edge.
- R3: Address 4 holds the group enable and address 5 the group edge select. Bit k of each applies to all pins of port k+2, with the same edge encoding as R2.
- R4: A pending flag becomes visible at the third rising clock edge after the pin changes. The input passes through two synchronizer flops and a previous-value flop. Read data is registered: `rd_data_o` shows the register at `addr_i` one clock after the address is presented.
- R5: Pending flags for ports 0 to 4 are at addresses 8 to 12, bit b for pin b. Each flag stays set until a write with a 1 in its bit position. Writing 0 leaves a flag unchanged.
- R6: `port_irq_o[p]` is high exactly when any pending flag of port p is set, and it changes on the same clock edge as the flags.
- R7: Pins 2, 3 and 4 of port 0 set dedicated flags, readable at address 13 bits 0 to 2. These flags drive `ded_irq_o[2:0]`. They use the port-0 enable and edge settings for those pins.
- R8: A write to address 13 leaves the port-0 pending flags unchanged. A write to address 8 leaves the dedicated flags unchanged.
- R9: If the selected edge and a clearing write for the same flag fall in the same cycle, the flag stays set.
- R10: A disabled pin, or an edge of the unselected direction, never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 40 | Pin inputs; port p occupies bits p*8+7 to p*8 |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register address for write and read |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| port_irq_o | output | 5 | Port-level requests |
| ded_irq_o | output | 3 | Dedicated requests for port-0 pins 2 to 4 |

## Verification
A detected edge and a software clear can hit the same pending flag on the same clock edge. The bench provokes this by changing a pin and then issuing the clearing write exactly two clocks later, so both the edge and the clear land on the third edge. It does this for a shared port-0 flag and for a dedicated flag. It then reads the flag back and requires it to be set. The bench also clears the shared and the dedicated flag of one pin in turn, and checks that each clear leaves the other flag intact.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned PORTS         = 5;
  localparam int unsigned PIN_CFG_PORTS = 2;
  localparam int unsigned GRP_PORTS     = PORTS - PIN_CFG_PORTS;
  localparam int unsigned DED_FIRST     = 2;
  localparam int unsigned DED_NUM       = 3;
  localparam int unsigned ADDR_W        = 4;

  localparam logic [ADDR_W-1:0] A_EN0   = 4'd0;
  localparam logic [ADDR_W-1:0] A_POL0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_GEN   = 4'd4;
  localparam logic [ADDR_W-1:0] A_GPOL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_PEND0 = 4'd8;
  localparam logic [ADDR_W-1:0] A_DED   = 4'd13;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[LAST];
    end
  end

  assign rise_o = stg_q[LAST] & ~prev_q;
  assign fall_o = ~stg_q[LAST] & prev_q;
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [PORT_W-1:0]              wr_data_i,
  output logic [PIN_CFG_PORTS-1:0][PORT_W-1:0] en_pin_o,
  output logic [PIN_CFG_PORTS-1:0][PORT_W-1:0] pol_pin_o,
  output logic [GRP_PORTS-1:0]           grp_en_o,
  output logic [GRP_PORTS-1:0]           grp_pol_o,
  output logic [PORTS-1:0][PORT_W-1:0]   en_o,
  output logic [PORTS-1:0][PORT_W-1:0]   pol_o
);
  logic [PIN_CFG_PORTS-1:0][PORT_W-1:0] en_pin_q, pol_pin_q;
  logic [GRP_PORTS-1:0]                 grp_en_q, grp_pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_pin_q  <= '0;
      pol_pin_q <= '0;
      grp_en_q  <= '0;
      grp_pol_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < PIN_CFG_PORTS; i++) begin
        if (addr_i == A_EN0 + ADDR_W'(i))  en_pin_q[i]  <= wr_data_i;
        if (addr_i == A_POL0 + ADDR_W'(i)) pol_pin_q[i] <= wr_data_i;
      end
      if (addr_i == A_GEN)  grp_en_q  <= wr_data_i[GRP_PORTS-1:0];
      if (addr_i == A_GPOL) grp_pol_q <= wr_data_i[GRP_PORTS-1:0];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_expand
    if (p < PIN_CFG_PORTS) begin : g_pin
      assign en_o[p]  = en_pin_q[p];
      assign pol_o[p] = pol_pin_q[p];
    end else begin : g_grp
      assign en_o[p]  = {PORT_W{grp_en_q[p-PIN_CFG_PORTS]}};
      assign pol_o[p] = {PORT_W{grp_pol_q[p-PIN_CFG_PORTS]}};
    end
  end

  assign en_pin_o  = en_pin_q;
  assign pol_pin_o = pol_pin_q;
  assign grp_en_o  = grp_en_q;
  assign grp_pol_o = grp_pol_q;

  // R3
  grp_expand_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en_i) && $past(addr_i) == A_GEN) |->
      en_o[PIN_CFG_PORTS] == {PORT_W{$past(wr_data_i[0])}});
endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q, pend_d;
  logic         irq_q;

  assign pend_d = (pend_q & ~clr_i) | hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |pend_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hit_i) & ~pend_q) == '0);
  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_i & ~hit_i) & pend_q) == '0);
  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_q & ~clr_i) & ~pend_q) == '0);
  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|pend_q));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PORTS*PORT_W-1:0]   pins_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [PORT_W-1:0]         wr_data_i,
  output logic [PORT_W-1:0]         rd_data_o,
  output logic [PORTS-1:0]          port_irq_o,
  output logic [DED_NUM-1:0]        ded_irq_o
);
  logic [PIN_CFG_PORTS-1:0][PORT_W-1:0] en_pin, pol_pin;
  logic [GRP_PORTS-1:0]                 grp_en, grp_pol;
  logic [PORTS-1:0][PORT_W-1:0]         en_x, pol_x, rise, fall, hit, clr, pend;
  logic [DED_NUM-1:0]                   ded_hit, ded_clr, ded_pend;
  logic [PORT_W-1:0]                    rd_mux, rd_q;

  gpio_irq_cfg #(.PORT_W(PORT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .en_pin_o  (en_pin),
    .pol_pin_o (pol_pin),
    .grp_en_o  (grp_en),
    .grp_pol_o (grp_pol),
    .en_o      (en_x),
    .pol_o     (pol_x)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pins_i[p*PORT_W +: PORT_W]),
      .rise_o (rise[p]),
      .fall_o (fall[p])
    );

    assign hit[p] = en_x[p] & ((pol_x[p] & rise[p]) | (~pol_x[p] & fall[p]));
    assign clr[p] = (wr_en_i && addr_i == A_PEND0 + ADDR_W'(p)) ? wr_data_i : '0;

    gpio_irq_pend #(.W(PORT_W)) u_pend (
      .clk    (clk),
      .rst    (rst),
      .hit_i  (hit[p]),
      .clr_i  (clr[p]),
      .pend_o (pend[p]),
      .irq_o  (port_irq_o[p])
    );

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (pend[p] & ~$past(pend[p]) & ~$past(en_x[p])) == '0);
  end

  assign ded_hit = hit[0][DED_FIRST +: DED_NUM];
  assign ded_clr = (wr_en_i && addr_i == A_DED) ? wr_data_i[DED_NUM-1:0] : '0;

  gpio_irq_pend #(.W(DED_NUM)) u_ded (
    .clk    (clk),
    .rst    (rst),
    .hit_i  (ded_hit),
    .clr_i  (ded_clr),
    .pend_o (ded_pend),
    .irq_o  ()
  );

  assign ded_irq_o = ded_pend;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < PIN_CFG_PORTS; i++) begin
      if (addr_i == A_EN0 + ADDR_W'(i))  rd_mux = en_pin[i];
      if (addr_i == A_POL0 + ADDR_W'(i)) rd_mux = pol_pin[i];
    end
    if (addr_i == A_GEN)  rd_mux[GRP_PORTS-1:0] = grp_en;
    if (addr_i == A_GPOL) rd_mux[GRP_PORTS-1:0] = grp_pol;
    if (addr_i == A_DED)  rd_mux[DED_NUM-1:0]   = ded_pend;
    for (int p = 0; p < PORTS; p++) begin
      if (addr_i == A_PEND0 + ADDR_W'(p)) rd_mux = pend[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  // R8
  ded_clear_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en_i) && $past(addr_i) == A_DED) |->
      ((pend[0] & $past(pend[0])) == $past(pend[0])));
  // R8
  port_clear_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en_i) && $past(addr_i) == A_PEND0) |->
      ((ded_pend & $past(ded_pend)) == $past(ded_pend)));
  // R7
  ded_follows_port_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hit[0][DED_FIRST +: DED_NUM]) & ~ded_pend) == '0);
endmodule

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb_top;
  localparam logic [3:0] EN0 = 4'd0, POL0 = 4'd2, GEN = 4'd4, GPOL = 4'd5;
  localparam logic [3:0] PEND0 = 4'd8, DED = 4'd13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic [4:0]  port_irq;
  logic [2:0]  ded_irq;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq dut_i (
    .clk (clk), .rst (rst), .pins_i (pins), .wr_en_i (wr_en),
    .addr_i (addr), .wr_data_i (wdata), .rd_data_o (rd_data),
    .port_irq_o (port_irq), .ded_irq_o (ded_irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic set_pin(input int p, input int b, input logic v);
    @(negedge clk);
    pins[p*8+b] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: every register and both request buses clear after reset
    for (int a = 0; a < 14; a++) begin
      rd(4'(a), v);
      chk("R1 reg", v, 8'h00);
    end
    chk("R1 port_irq", {3'b0, port_irq}, 8'h00);
    chk("R1 ded_irq", {5'b0, ded_irq}, 8'h00);

    // R2/R3/R5/R6/R7/R10: sweep every pin and both edge selections
    for (int p = 0; p < 5; p++) begin
      for (int b = 0; b < 8; b++) begin
        for (int pol = 0; pol < 2; pol++) begin
          logic [7:0] bit_m;
          bit_m = 8'(1 << b);
          if (p < 2) begin
            wr(EN0 + 4'(p), bit_m);
            wr(POL0 + 4'(p), pol ? bit_m : 8'h00);
          end else begin
            wr(GEN, 8'(1 << (p-2)));
            wr(GPOL, pol ? 8'(1 << (p-2)) : 8'h00);
          end
          set_pin(p, b, 1'b1);
          rd(PEND0 + 4'(p), v);
          chk(p < 2 ? "R2 rise pend" : "R3 rise pend", v, pol ? bit_m : 8'h00);
          chk("R6 irq after rise", {3'b0, port_irq}, pol ? 8'(1 << p) : 8'h00);
          set_pin(p, b, 1'b0);
          rd(PEND0 + 4'(p), v);
          chk(p < 2 ? "R2 fall pend" : "R3 fall pend", v, bit_m);
          chk("R6 irq after fall", {3'b0, port_irq}, 8'(1 << p));
          rd(DED, v);
          chk("R7 dedicated", v, (p == 0 && b >= 2 && b <= 4) ? 8'(1 << (b-2)) : 8'h00);
          chk("R7 ded_irq", {5'b0, ded_irq}, (p == 0 && b >= 2 && b <= 4) ? 8'(1 << (b-2)) : 8'h00);
          wr(PEND0 + 4'(p), 8'h00);
          rd(PEND0 + 4'(p), v);
          chk("R5 zero write keeps", v, bit_m);
          wr(PEND0 + 4'(p), 8'hFF);
          wr(DED, 8'h07);
          rd(PEND0 + 4'(p), v);
          chk("R5 cleared", v, 8'h00);
          chk("R6 irq cleared", {3'b0, port_irq}, 8'h00);
          if (p < 2) wr(EN0 + 4'(p), 8'h00);
          else       wr(GEN, 8'h00);
        end
      end
    end

    // R10: disabled pins and other ports stay quiet
    set_pin(1, 6, 1'b1); set_pin(1, 6, 1'b0);
    rd(PEND0 + 4'd1, v);
    chk("R10 disabled pin", v, 8'h00);
    wr(GEN, 8'h01);
    set_pin(3, 1, 1'b1); set_pin(3, 1, 1'b0);
    rd(PEND0 + 4'd3, v);
    chk("R10 other group port", v, 8'h00);
    chk("R10 irq quiet", {3'b0, port_irq}, 8'h00);
    wr(GEN, 8'h00);

    // R4: latency of three clock edges
    wr(EN0 + 4'd1, 8'h01);
    wr(POL0 + 4'd1, 8'h01);
    @(negedge clk) pins[8] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4 not yet", {3'b0, port_irq}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chk("R4 third edge", {3'b0, port_irq}, 8'h02);
    set_pin(1, 0, 1'b0);
    wr(PEND0 + 4'd1, 8'hFF);
    wr(EN0 + 4'd1, 8'h00);

    // R9: edge and clear on the same edge, shared then dedicated flag
    wr(EN0, 8'h04);
    wr(POL0, 8'h04);
    set_pin(0, 2, 1'b1);
    set_pin(0, 2, 1'b0);
    @(negedge clk) pins[2] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) begin wr_en = 1'b1; addr = PEND0; wdata = 8'hFF; end
    @(negedge clk) wr_en = 1'b0;
    rd(PEND0, v);
    chk("R9 shared set wins", v, 8'h04);
    rd(DED, v);
    chk("R9 ded untouched", v, 8'h01);
    set_pin(0, 2, 1'b0);
    @(negedge clk) pins[2] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) begin wr_en = 1'b1; addr = DED; wdata = 8'h07; end
    @(negedge clk) wr_en = 1'b0;
    rd(DED, v);
    chk("R9 ded set wins", v, 8'h01);

    // R8: independent clears of shared and dedicated flags
    wr(DED, 8'h01);
    rd(DED, v);
    chk("R8 ded cleared", v, 8'h00);
    rd(PEND0, v);
    chk("R8 shared kept", v, 8'h04);
    set_pin(0, 2, 1'b0);
    set_pin(0, 2, 1'b1);
    wr(PEND0, 8'hFF);
    rd(PEND0, v);
    chk("R8 shared cleared", v, 8'h00);
    rd(DED, v);
    chk("R8 ded kept", v, 8'h01);
    chk("R8 ded_irq kept", {5'b0, ded_irq}, 8'h01);

    finish_run();
  end
endmodule